// File: doc/BRIEF.md
# Two-Port Video RAM Request Arbiter

This block lets two requesters share one single-port, byte-wide video RAM. Port A faces a host-processor bus bridge whose write strobe lasts a couple of clocks and whose read strobe lasts one clock. Port B faces a serial debug link whose strobes stay high for many clocks. Each port turns a strobe into exactly one request, keeps it in a one-entry holding register with its own address and data, and waits there until the arbiter picks that port.

The arbiter issues at most one RAM access per clock. A port that is alone in waiting is served at once. When both are waiting, the port that was not served last goes first. Reads are tagged with their source port as they go to the RAM. When the data comes back after a fixed latency, the tag routes it to the right port, together with a one-clock ready strobe. If a port's holding register is overwritten before it is served, a saturating counter for that port records the loss.

Top module: `vram_arbiter`

## Requirements
- R1: An asynchronous active-low reset empties both holding registers, clears both overrun counters, holds the RAM write enable and both ready strobes low, and points the turn at port A, so that the first pair of simultaneous requests after reset serves port A first.
- R2: A request held is kept until it is issued. A write reaches the RAM as a write-enable pulse of exactly one clock that carries the address and data present on the clock the request was captured, even if the port inputs change afterwards.
- R3: A request is made only by a rising edge on a port's write-enable or read-request line (low on the previous clock, high on this one). A line held high for any number of clocks produces exactly one RAM access, and a new access needs the line to go low for at least one clock first.
- R4: A read returns its byte on the requesting port's read-data output with a one-clock read-ready pulse, RD_LAT+1 clocks after its address was presented to the RAM. When the port is served at once, this is RD_LAT+3 clocks after the request edge. The other port gives no ready pulse.
- R5: When only one port has a pending request, it is served on the next clock: its RAM access is presented two clocks after the rising request edge.
- R6: When both ports are pending, the port that was not served most recently is served first and the other port on the next clock.
- R7: When a new request edge arrives on a port whose held request is not served in that same clock, the new request replaces the held one and the port's overrun counter increments by one, saturating at all ones. The replaced request never reaches the RAM.
- R8: When the write-enable and read-request lines of one port both rise on the same clock, the port makes a single write and gives no ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | AW (19) | Port A byte address |
| a_wdata | input | DW (8) | Port A write data |
| a_we | input | 1 | Port A write enable, rising edge makes a write |
| a_rd | input | 1 | Port A read request, rising edge makes a read |
| a_rdata | output | DW (8) | Port A returned read byte |
| a_rdy | output | 1 | Port A one-clock read-ready strobe |
| a_ovr_cnt | output | OVR_W (8) | Port A saturating overrun count |
| b_addr | input | AW (19) | Port B byte address |
| b_wdata | input | DW (8) | Port B write data |
| b_we | input | 1 | Port B write enable, rising edge makes a write |
| b_rd | input | 1 | Port B read request, rising edge makes a read |
| b_rdata | output | DW (8) | Port B returned read byte |
| b_rdy | output | 1 | Port B one-clock read-ready strobe |
| b_ovr_cnt | output | OVR_W (8) | Port B saturating overrun count |
| ram_addr | output | AW (19) | RAM address |
| ram_wdata | output | DW (8) | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DW (8) | RAM read data, valid RD_LAT clocks after the address |

## Verification
The hardest case to reach is an overrun. With strict alternation a held request waits at most one clock, while a single line cannot make a new edge sooner than two clocks later. So the same line can never overwrite its own pending request. The bench gets there by first serving port A alone, so that the turn points at port B. It then raises port A's read line together with a port B write, and on the next clock raises port A's write line while port B is being served. The check then confirms that port A's counter reads one, that no ready pulse comes for the dropped read, and that the two RAM writes occur in the order B then A.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // Source port of an access; also the encoding of the turn pointer.
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

endpackage

// File: rtl/vram_req_capture.sv
// One port's front end: edge detection on both strobes, a one-entry
// holding register and a saturating overrun counter.
module vram_req_capture #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          grant_i,
  output logic          pend_o,
  output logic          pend_we_o,
  output logic [AW-1:0] pend_addr_o,
  output logic [DW-1:0] pend_wdata_o,
  output logic [CW-1:0] ovr_cnt_o
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          we_d_q, rd_d_q;
  logic          pend_q, pend_n;
  logic          kind_q, kind_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_edge, rd_edge, new_req, ovr;

  // Next state
  always_comb begin
    we_edge = we_i & ~we_d_q;
    rd_edge = rd_i & ~rd_d_q;
    new_req = we_edge | rd_edge;
    ovr     = new_req & pend_q & ~grant_i;

    pend_n = pend_q & ~grant_i;
    kind_n = kind_q;
    if (new_req) begin
      pend_n = 1'b1;
      kind_n = we_edge;            // a write edge wins over a read edge
    end

    cnt_n = cnt_q;
    if (ovr && (cnt_q != CNT_MAX)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d_q <= 1'b0;
      rd_d_q <= 1'b0;
      pend_q <= 1'b0;
      kind_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      we_d_q <= we_i;
      rd_d_q <= rd_i;
      pend_q <= pend_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
    end
  end

  // Payload registers, loaded only on a new request
  always_ff @(posedge clk) begin
    if (new_req) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign pend_o       = pend_q;
  assign pend_we_o    = kind_q;
  assign pend_addr_o  = addr_q;
  assign pend_wdata_o = wdata_q;
  assign ovr_cnt_o    = cnt_q;

  // R2: a held request stays until the arbiter serves it
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant_i) |=> pend_q);

  // R7: an overwritten, unserved request bumps the counter by one
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (new_req && pend_q && !grant_i && (cnt_q != CNT_MAX)) |=>
      (cnt_q == $past(cnt_q) + 1'b1));

  // R7: the counter saturates
  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/vram_grant_sel.sv
// Picks at most one pending port per clock; alternates under contention.
module vram_grant_sel
  import vram_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pend_a_i,
  input  logic pend_b_i,
  output logic gnt_a_o,
  output logic gnt_b_o
);

  port_e turn_q, turn_n;

  always_comb begin
    gnt_a_o = pend_a_i & (~pend_b_i | (turn_q == PORT_A));
    gnt_b_o = pend_b_i & (~pend_a_i | (turn_q == PORT_B));
    turn_n  = turn_q;
    if (gnt_a_o) begin
      turn_n = PORT_B;
    end else if (gnt_b_o) begin
      turn_n = PORT_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= PORT_A;
    end else begin
      turn_q <= turn_n;
    end
  end

endmodule

// File: rtl/vram_rd_return.sv
// Carries a source tag alongside each read for LAT clocks and routes the
// returning byte with a ready strobe to the port that asked for it.
module vram_rd_return
  import vram_arb_pkg::*;
#(
  parameter int LAT = 2,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_rd_i,
  input  port_e         iss_src_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          rdy_a_o,
  output logic          rdy_b_o,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);

  localparam int NPORT = 2;

  logic [LAT-1:0] vld_q, vld_n;
  logic [LAT-1:0] src_q, src_n;
  logic           tag_vld;
  logic           tag_src;

  always_comb begin
    vld_n = (vld_q << 1) | LAT'(iss_rd_i);
    src_n = (src_q << 1) | LAT'(iss_src_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      src_q <= '0;
    end else begin
      vld_q <= vld_n;
      src_q <= src_n;
    end
  end

  assign tag_vld = vld_q[LAT-1];
  assign tag_src = src_q[LAT-1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic          hit;
    logic          rdy_r;
    logic [DW-1:0] dat_r;

    assign hit = tag_vld && (tag_src == 1'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_r <= 1'b0;
      end else begin
        rdy_r <= hit;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        dat_r <= ram_rdata_i;
      end
    end
  end

  assign rdy_a_o   = g_port[0].rdy_r;
  assign rdy_b_o   = g_port[1].rdy_r;
  assign rdata_a_o = g_port[0].dat_r;
  assign rdata_b_o = g_port[1].dat_r;

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
  import vram_arb_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int RD_LAT = 2,
  parameter int OVR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_wdata,
  input  logic             a_we,
  input  logic             a_rd,
  output logic [DW-1:0]    a_rdata,
  output logic             a_rdy,
  output logic [OVR_W-1:0] a_ovr_cnt,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_wdata,
  input  logic             b_we,
  input  logic             b_rd,
  output logic [DW-1:0]    b_rdata,
  output logic             b_rdy,
  output logic [OVR_W-1:0] b_ovr_cnt,
  output logic [AW-1:0]    ram_addr,
  output logic [DW-1:0]    ram_wdata,
  output logic             ram_we,
  input  logic [DW-1:0]    ram_rdata
);

  logic          pend_a, pend_b;
  logic          pa_we, pb_we;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [DW-1:0] pa_wdata, pb_wdata;
  logic          gnt_a, gnt_b;

  logic          fire;
  logic          sel_we;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;

  logic          we_q, we_n;
  logic          rd_q, rd_n;
  port_e         src_q, src_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  vram_req_capture #(.AW(AW), .DW(DW), .CW(OVR_W)) u_cap_a (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (a_we),
    .rd_i         (a_rd),
    .addr_i       (a_addr),
    .wdata_i      (a_wdata),
    .grant_i      (gnt_a),
    .pend_o       (pend_a),
    .pend_we_o    (pa_we),
    .pend_addr_o  (pa_addr),
    .pend_wdata_o (pa_wdata),
    .ovr_cnt_o    (a_ovr_cnt)
  );

  vram_req_capture #(.AW(AW), .DW(DW), .CW(OVR_W)) u_cap_b (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (b_we),
    .rd_i         (b_rd),
    .addr_i       (b_addr),
    .wdata_i      (b_wdata),
    .grant_i      (gnt_b),
    .pend_o       (pend_b),
    .pend_we_o    (pb_we),
    .pend_addr_o  (pb_addr),
    .pend_wdata_o (pb_wdata),
    .ovr_cnt_o    (b_ovr_cnt)
  );

  vram_grant_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_a_i (pend_a),
    .pend_b_i (pend_b),
    .gnt_a_o  (gnt_a),
    .gnt_b_o  (gnt_b)
  );

  // Issue stage: next state
  always_comb begin
    fire      = gnt_a | gnt_b;
    sel_we    = gnt_b ? pb_we    : pa_we;
    sel_addr  = gnt_b ? pb_addr  : pa_addr;
    sel_wdata = gnt_b ? pb_wdata : pa_wdata;

    we_n  = fire & sel_we;
    rd_n  = fire & ~sel_we;
    src_n = gnt_b ? PORT_B : PORT_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      rd_q  <= 1'b0;
      src_q <= PORT_A;
    end else begin
      we_q  <= we_n;
      rd_q  <= rd_n;
      src_q <= src_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      addr_q  <= sel_addr;
      wdata_q <= sel_wdata;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;

  vram_rd_return #(.LAT(RD_LAT), .DW(DW)) u_ret (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_rd_i    (rd_q),
    .iss_src_i   (src_q),
    .ram_rdata_i (ram_rdata),
    .rdy_a_o     (a_rdy),
    .rdy_b_o     (b_rdy),
    .rdata_a_o   (a_rdata),
    .rdata_b_o   (b_rdata)
  );

  // R6: under contention the loser is served on the very next clock
  p_alt_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && pend_b && gnt_a) |=> gnt_b);
  p_alt_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && pend_b && gnt_b) |=> gnt_a);

  // R2: the RAM write enable rises only after a grant
  p_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(gnt_a || gnt_b));

  // R2: nothing held means no RAM write on the next clock
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_a && !pend_b) |=> !ram_we);

endmodule

// File: tb/tb_vram_arbiter.sv
module tb_vram_arbiter;

  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam int OW  = 8;

  typedef struct packed {
    logic          prt;   // 0 = port A, 1 = port B
    logic          wr;
    logic [7:0]    hold;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 8'd2, 19'h00010, 8'h3C},
    '{1'b0, 1'b0, 8'd1, 19'h00010, 8'h3C},
    '{1'b1, 1'b1, 8'd6, 19'h00011, 8'hC3},
    '{1'b1, 1'b0, 8'd5, 19'h00011, 8'hC3},
    '{1'b0, 1'b0, 8'd1, 19'h001FF, 8'h00},
    '{1'b1, 1'b0, 8'd3, 19'h00000, 8'h00},
    '{1'b1, 1'b1, 8'd9, 19'h001FF, 8'h00},
    '{1'b0, 1'b0, 8'd1, 19'h001FF, 8'h00},
    '{1'b0, 1'b1, 8'd3, 19'h000AA, 8'h55},
    '{1'b1, 1'b0, 8'd4, 19'h000AA, 8'h55},
    '{1'b1, 1'b1, 8'd1, 19'h00100, 8'hFF},
    '{1'b0, 1'b0, 8'd1, 19'h00100, 8'hFF}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] a_addr, b_addr, ram_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata, ram_wdata, ram_rdata;
  logic          a_we, a_rd, a_rdy, b_we, b_rd, b_rdy, ram_we;
  logic [OW-1:0] a_ovr_cnt, b_ovr_cnt;

  always #10 clk = ~clk;

  vram_arbiter #(.AW(AW), .DW(DW), .RD_LAT(LAT), .OVR_W(OW)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rd(a_rd),
    .a_rdata(a_rdata), .a_rdy(a_rdy), .a_ovr_cnt(a_ovr_cnt),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rd(b_rd),
    .b_rdata(b_rdata), .b_rdy(b_rdy), .b_ovr_cnt(b_ovr_cnt),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata)
  );

  // RAM model with fixed read latency
  logic [DW-1:0] mem [512];
  logic [DW-1:0] rpipe [LAT];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr[8:0]] <= ram_wdata;
    rpipe[0] <= mem[ram_addr[8:0]];
    for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
  end
  assign ram_rdata = rpipe[LAT-1];

  // Expected RAM contents
  logic [DW-1:0] expm [512];

  // Port-side monitor
  int            wr_cnt = 0, ra_cnt = 0, rb_cnt = 0;
  logic [AW-1:0] wl_addr [32];
  logic [DW-1:0] wl_data [32];
  always @(negedge clk) begin
    if (ram_we) begin
      wl_addr[wr_cnt % 32] = ram_addr;
      wl_data[wr_cnt % 32] = ram_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (a_rdy) ra_cnt = ra_cnt + 1;
    if (b_rdy) rb_cnt = rb_cnt + 1;
  end

  int  total = 0, bad = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic drive_op(input bit prt, input bit wr, input logic [AW-1:0] ad,
                          input logic [DW-1:0] dt, input int hold);
    @(negedge clk);
    if (!prt) begin
      a_addr = ad; a_wdata = dt;
      if (wr) a_we = 1'b1; else a_rd = 1'b1;
    end else begin
      b_addr = ad; b_wdata = dt;
      if (wr) b_we = 1'b1; else b_rd = 1'b1;
    end
    repeat (hold) @(negedge clk);
    a_we = 1'b0; a_rd = 1'b0; b_we = 1'b0; b_rd = 1'b0;
  endtask

  // Both ports write on the same clock
  task automatic both_write(input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                            input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    @(negedge clk);
    a_addr = aa; a_wdata = ad; a_we = 1'b1;
    b_addr = ba; b_wdata = bd; b_we = 1'b1;
    repeat (2) @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    expm[aa[8:0]] = ad;
    expm[ba[8:0]] = bd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, a0, b0;
    rst_n = 1'b0;
    a_addr = '0; a_wdata = '0; a_we = 1'b0; a_rd = 1'b0;
    b_addr = '0; b_wdata = '0; b_we = 1'b0; b_rd = 1'b0;
    for (int i = 0; i < 512; i++) begin
      mem[i]  = 8'(i) ^ 8'hA5;
      expm[i] = 8'(i) ^ 8'hA5;
    end

    // R1: reset state
    settle(3);
    chk("R1", "ram_we in reset", ram_we, 0);
    chk("R1", "ready strobes in reset", {a_rdy, b_rdy}, 0);
    chk("R1", "overrun counts in reset", {a_ovr_cnt, b_ovr_cnt}, 0);
    @(negedge clk); rst_n = 1'b1;
    settle(2);

    // R1/R6: first contention after reset serves A first
    w0 = wr_cnt;
    both_write(19'h020, 8'h11, 19'h021, 8'h22);
    settle(6);
    chk("R6", "write count for pair", wr_cnt - w0, 2);
    chk("R1", "first served after reset", wl_addr[w0 % 32], 19'h020);
    chk("R6", "second served", wl_addr[(w0 + 1) % 32], 19'h021);

    // R5/R2/R3: lone B write, exact timing, one pulse despite held line
    @(negedge clk);
    b_addr = 19'h030; b_wdata = 8'h77; b_we = 1'b1;
    @(negedge clk);
    chk("R5", "ram_we one clock after edge", ram_we, 0);
    b_addr = 19'h7FFFF; b_wdata = 8'h00;       // inputs change while held
    @(negedge clk);
    chk("R5", "ram_we two clocks after edge", ram_we, 1);
    chk("R2", "captured address", ram_addr, 19'h030);
    chk("R2", "captured data", ram_wdata, 8'h77);
    @(negedge clk);
    chk("R2", "write pulse one clock", ram_we, 0);
    b_we = 1'b0;
    expm[9'h030] = 8'h77;
    settle(4);

    // R4: lone A read, exact ready timing
    a0 = ra_cnt; b0 = rb_cnt;
    @(negedge clk);
    a_addr = 19'h030; a_rd = 1'b1;
    @(negedge clk); a_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", "no ready at RD_LAT+2", a_rdy, 0);
    @(negedge clk);
    chk("R4", "ready at RD_LAT+3", a_rdy, 1);
    chk("R4", "read byte", a_rdata, 8'h77);
    @(negedge clk);
    chk("R4", "ready is one clock", a_rdy, 0);
    settle(3);
    chk("R4", "other port silent", rb_cnt - b0, 0);

    // R6: alternation; turn now at B after the lone A read
    w0 = wr_cnt;
    both_write(19'h040, 8'hA1, 19'h041, 8'hB1);
    settle(6);
    chk("R6", "B first after A was last", wl_addr[w0 % 32], 19'h041);
    chk("R6", "A second", wl_addr[(w0 + 1) % 32], 19'h040);
    drive_op(1'b1, 1'b1, 19'h042, 8'hB2, 2);
    expm[9'h042] = 8'hB2;
    settle(6);
    w0 = wr_cnt;
    both_write(19'h043, 8'hA3, 19'h044, 8'hB3);
    settle(6);
    chk("R6", "A first after B was last", wl_addr[w0 % 32], 19'h043);

    // R7: overrun. Serve A alone so the turn points at B.
    drive_op(1'b0, 1'b1, 19'h050, 8'h5A, 2);
    expm[9'h050] = 8'h5A;
    settle(6);
    w0 = wr_cnt; a0 = ra_cnt;
    @(negedge clk);
    a_addr = 19'h051; a_rd = 1'b1;
    b_addr = 19'h052; b_wdata = 8'hB5; b_we = 1'b1;
    @(negedge clk);
    a_addr = 19'h053; a_wdata = 8'hA5; a_we = 1'b1;
    @(negedge clk);
    a_rd = 1'b0; a_we = 1'b0; b_we = 1'b0;
    expm[9'h052] = 8'hB5; expm[9'h053] = 8'hA5;
    settle(8);
    chk("R7", "A overrun count", a_ovr_cnt, 1);
    chk("R7", "B overrun count", b_ovr_cnt, 0);
    chk("R7", "dropped read gives no ready", ra_cnt - a0, 0);
    chk("R7", "write count", wr_cnt - w0, 2);
    chk("R7", "B write first", wl_addr[w0 % 32], 19'h052);
    chk("R7", "replacing write address", wl_addr[(w0 + 1) % 32], 19'h053);
    chk("R7", "replacing write data", wl_data[(w0 + 1) % 32], 8'hA5);

    // R8: write and read edges together on one port
    w0 = wr_cnt; a0 = ra_cnt;
    @(negedge clk);
    a_addr = 19'h060; a_wdata = 8'h66; a_we = 1'b1; a_rd = 1'b1;
    @(negedge clk);
    a_we = 1'b0; a_rd = 1'b0;
    expm[9'h060] = 8'h66;
    settle(8);
    chk("R8", "single write", wr_cnt - w0, 1);
    chk("R8", "no ready", ra_cnt - a0, 0);
    chk("R8", "written data", wl_data[w0 % 32], 8'h66);

    // Vector table: R2, R3, R4
    for (int v = 0; v < 12; v++) begin
      w0 = wr_cnt; a0 = ra_cnt; b0 = rb_cnt;
      drive_op(VEC[v].prt, VEC[v].wr, VEC[v].addr, VEC[v].data, int'(VEC[v].hold));
      settle(10);
      if (VEC[v].wr) begin
        chk("R3", $sformatf("vec %0d write count", v), wr_cnt - w0, 1);
        chk("R2", $sformatf("vec %0d write addr", v), wl_addr[w0 % 32], VEC[v].addr);
        chk("R2", $sformatf("vec %0d write data", v), wl_data[w0 % 32], VEC[v].data);
        chk("R4", $sformatf("vec %0d no ready on write", v), (ra_cnt - a0) + (rb_cnt - b0), 0);
        expm[VEC[v].addr[8:0]] = VEC[v].data;
      end else begin
        chk("R3", $sformatf("vec %0d no write on read", v), wr_cnt - w0, 0);
        chk("R4", $sformatf("vec %0d ready A", v), ra_cnt - a0, VEC[v].prt ? 0 : 1);
        chk("R4", $sformatf("vec %0d ready B", v), rb_cnt - b0, VEC[v].prt ? 1 : 0);
        chk("R4", $sformatf("vec %0d read byte", v),
            VEC[v].prt ? b_rdata : a_rdata, expm[VEC[v].addr[8:0]]);
      end
    end

    // R1: reset mid-run clears counts and turn
    @(negedge clk); rst_n = 1'b0;
    settle(2);
    chk("R1", "overrun after reset", a_ovr_cnt, 0);
    chk("R1", "ram_we after reset", ram_we, 0);
    @(negedge clk); rst_n = 1'b1;
    settle(2);
    w0 = wr_cnt;
    both_write(19'h070, 8'h07, 19'h071, 8'h17);
    settle(6);
    chk("R1", "turn back at A", wl_addr[w0 % 32], 19'h070);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule